// File: doc/BRIEF.md
# Dual-Bus CAN Relay Core

This block is the digital heart of a two-channel CAN front end. It sits between one protocol controller and two bus-side transceiver channels. It merges everything that is dominant anywhere, whether on the controller's transmit line, on an expansion input from a neighbouring device, or on either bus, into a drive request toward both buses. It also reports the merged state back to the controller. An expansion receive output lets several such cores be chained, so that a node can serve more than two buses.

Every digital pin uses the same convention: low means dominant and high means recessive. Each bus has an active-low enable. When the enable is high, that channel is cut off both ways. The receive bits from the bus comparators are asynchronous and enter through a synchroniser.

The core drives a bus and then hears its own drive come back from that same bus. Relaying that echo to the other bus would hold both buses dominant for ever. Each bus therefore has its own suppression circuit, and both circuits are identical:
- A dominant level seen on a bus is masked while the core is driving that bus.
- The mask stays on for a hold time after the drive stops.
- A bus that was already dominant before the core started driving it stays a genuine source until it releases.
- After an outside node releases a bus, a fresh drive toward that bus is locked out for a short time.

Top module: `canBusRelay`

## Requirements
- R1: On every pin a low level is dominant and a high level is recessive. After reset, with all inputs high, every output is high.
- R2: When `ctrlTx` or `expTx` is low, the drive pin of each enabled bus goes low at the first clock edge that samples it. The lockout of R9 is the only exception.
- R3: A low receive bit on an enabled bus that the core is not driving pulls `ctrlRx` and `expRx` low once SYNC_STAGES edges have sampled it. The drive pin of the other enabled bus goes low one edge later.
- R4: `ctrlRx` is low whenever `ctrlTx` or `expTx` is low, whatever the enables are.
- R5: While a bus enable is high, that bus's drive pin is high in the same cycle, and that bus's receive bit is treated as recessive.
- R6: A dominant bit received on a bus while the core is driving that bus is not relayed to the other bus, to `ctrlRx` or to `expRx`.
- R7: Suppression lasts HOLD_CYC edges after the edge on which a bus's drive request drops. A dominant bit on that bus that outlasts the hold is relayed: the other bus's drive pin falls on edge HOLD_CYC+1 after the drop.
- R8: A bus that turned dominant before the core drove it keeps relaying until it releases. When both buses turn dominant together and then release one after the other, `ctrlRx`, `expRx` and both drive pins each fall once and rise once.
- R9: After a relaying bus returns recessive, a new drive toward it is held off. Counting from the first edge that samples the release, it can start no earlier than edge SYNC_STAGES+LOCK_CYC+1.
- R10: `expRx` is low exactly when `ctrlTx` is low or either bus is dominant after suppression. `expTx` has no effect on `expRx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlTx | input | 1 | Controller transmit bit, low = dominant |
| expTx | input | 1 | Expansion transmit input from a chained device, low = dominant |
| bus1EnN | input | 1 | Bus 1 enable, high disables the channel |
| bus2EnN | input | 1 | Bus 2 enable, high disables the channel |
| bus1Rx | input | 1 | Asynchronous comparator bit from bus 1, low = dominant |
| bus2Rx | input | 1 | Asynchronous comparator bit from bus 2, low = dominant |
| bus1DrvN | output | 1 | Bus 1 driver request, low = drive dominant |
| bus2DrvN | output | 1 | Bus 2 driver request, low = drive dominant |
| ctrlRx | output | 1 | Controller receive bit, low = dominant |
| expRx | output | 1 | Expansion receive output for chaining, low = dominant |

## Verification
The hardest situation to reach from the ports is a bus echo that outlasts the suppression hold. It matters only after the core has driven a bus, released it, and the bus still reads dominant. The bench gets there by playing the echo itself: it raises a bus's receive bit only after the core's drive pin toward that bus has fallen. It then keeps that bit low past the release of the source bus. The edge on which the relay reappears is checked, and so is the opposite case, an echo that clears inside the hold and never reaches the other bus. The lockout and the two-bus acknowledge case are also reached from idle by timed releases. An exhaustive sweep covers every static combination of the six inputs.

// File: rtl/canRelayPkg.sv
package canRelayPkg;
  localparam int NBUS = 2;

  // Per-bus strobes from the control to the datapath.
  typedef struct packed {
    logic [NBUS-1:0] drive;     // drive request (active high internally)
    logic [NBUS-1:0] suppress;  // mask own echo
    logic [NBUS-1:0] srcHeld;   // bus was a genuine source last cycle
  } laneStrobe_t;
endpackage

// File: rtl/canRelayLane.sv
module canRelayLane #(
  parameter int HOLD_CYC = 4,
  parameter int LOCK_CYC = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enN,
  input  logic wantDom,
  input  logic rxDom,
  input  logic effDom,
  output logic drive,
  output logic suppress,
  output logic srcHeld
);
  localparam int HW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
  localparam int LW = (LOCK_CYC < 1) ? 1 : $clog2(LOCK_CYC + 1);

  logic          drvQ, drvNext, srcQ;
  logic [HW-1:0] holdCnt;
  logic [LW-1:0] lockCnt;
  logic          lockBusy, releaseSeen;

  assign lockBusy    = (lockCnt != '0);
  // A fresh request is blocked while locked; an ongoing one continues.
  assign drvNext     = wantDom & ~enN & (drvQ | ~lockBusy);
  assign releaseSeen = srcQ & ~rxDom & ~enN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvQ    <= 1'b0;
      srcQ    <= 1'b0;
      holdCnt <= '0;
      lockCnt <= '0;
    end else begin
      drvQ <= drvNext;
      srcQ <= effDom;
      if (drvQ && !drvNext)   holdCnt <= HW'(HOLD_CYC);
      else if (holdCnt != '0) holdCnt <= holdCnt - HW'(1);
      if (releaseSeen)        lockCnt <= LW'(LOCK_CYC);
      else if (lockBusy)      lockCnt <= lockCnt - LW'(1);
    end
  end

  assign drive    = drvQ;
  assign suppress = drvQ | (holdCnt != '0);
  assign srcHeld  = srcQ;
endmodule

// File: rtl/canRelayControl.sv
module canRelayControl
  import canRelayPkg::*;
#(
  parameter int HOLD_CYC = 4,
  parameter int LOCK_CYC = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctrlTx,
  input  logic            expTx,
  input  logic [NBUS-1:0] enN,
  input  logic [NBUS-1:0] rxDom,
  input  logic [NBUS-1:0] effDom,
  output laneStrobe_t     strobe
);
  logic localDom;
  assign localDom = ~ctrlTx | ~expTx;

  for (genvar b = 0; b < NBUS; b++) begin : gLane
    localparam logic [NBUS-1:0] SELF = NBUS'(1) << b;
    logic wantDom;
    // Any dominant source except this bus itself asks for drive.
    assign wantDom = localDom | (|(effDom & ~SELF));

    canRelayLane #(.HOLD_CYC(HOLD_CYC), .LOCK_CYC(LOCK_CYC)) i_lane (
      .clk     (clk),
      .rstN    (rstN),
      .enN     (enN[b]),
      .wantDom (wantDom),
      .rxDom   (rxDom[b]),
      .effDom  (effDom[b]),
      .drive   (strobe.drive[b]),
      .suppress(strobe.suppress[b]),
      .srcHeld (strobe.srcHeld[b])
    );
  end
endmodule

// File: rtl/canRelayDatapath.sv
module canRelayDatapath
  import canRelayPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctrlTx,
  input  logic            expTx,
  input  logic [NBUS-1:0] enN,
  input  logic [NBUS-1:0] rxRaw,
  input  laneStrobe_t     strobe,
  output logic [NBUS-1:0] rxDom,
  output logic [NBUS-1:0] effDom,
  output logic [NBUS-1:0] drvN,
  output logic            ctrlRx,
  output logic            expRx
);
  for (genvar b = 0; b < NBUS; b++) begin : gBus
    logic [SYNC_STAGES-1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= '1;
      else       stage <= {stage[SYNC_STAGES-2:0], rxRaw[b]};
    end
    // Disabled bus reads recessive; echo masked unless bus is a held source.
    assign rxDom[b]  = ~stage[SYNC_STAGES-1] & ~enN[b];
    assign effDom[b] = rxDom[b] & (strobe.srcHeld[b] | ~strobe.suppress[b]);
    assign drvN[b]   = ~(strobe.drive[b] & ~enN[b]);
  end

  assign ctrlRx = ctrlTx & expTx & ~(|effDom);
  assign expRx  = ctrlTx & ~(|effDom);
endmodule

// File: rtl/canBusRelay.sv
module canBusRelay
  import canRelayPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 4,
  parameter int LOCK_CYC    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ctrlTx,
  input  logic expTx,
  input  logic bus1EnN,
  input  logic bus2EnN,
  input  logic bus1Rx,
  input  logic bus2Rx,
  output logic bus1DrvN,
  output logic bus2DrvN,
  output logic ctrlRx,
  output logic expRx
);
  laneStrobe_t     strobe;
  logic [NBUS-1:0] rxDom, effDom, drvN;
  logic [NBUS-1:0] enN, rxRaw;

  assign enN   = {bus2EnN, bus1EnN};
  assign rxRaw = {bus2Rx, bus1Rx};

  canRelayDatapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrlTx(ctrlTx),
    .expTx (expTx),
    .enN   (enN),
    .rxRaw (rxRaw),
    .strobe(strobe),
    .rxDom (rxDom),
    .effDom(effDom),
    .drvN  (drvN),
    .ctrlRx(ctrlRx),
    .expRx (expRx)
  );

  canRelayControl #(.HOLD_CYC(HOLD_CYC), .LOCK_CYC(LOCK_CYC)) i_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .ctrlTx(ctrlTx),
    .expTx (expTx),
    .enN   (enN),
    .rxDom (rxDom),
    .effDom(effDom),
    .strobe(strobe)
  );

  assign bus1DrvN = drvN[0];
  assign bus2DrvN = drvN[1];
endmodule

// File: rtl/canBusRelayChecker.sv
module canBusRelayChecker (
  input logic clk,
  input logic rstN,
  input logic ctrlTx,
  input logic expTx,
  input logic bus1EnN,
  input logic bus2EnN,
  input logic bus1DrvN,
  input logic bus2DrvN,
  input logic ctrlRx,
  input logic expRx
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  a_r5_bus1_off: assert property (@(posedge clk) disable iff (!rstN)
    bus1EnN |-> bus1DrvN);
  a_r5_bus2_off: assert property (@(posedge clk) disable iff (!rstN)
    bus2EnN |-> bus2DrvN);
  a_r4_ctrl_rx: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlTx || !expTx) |-> !ctrlRx);
  a_r10_exp_vs_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    !expRx |-> !ctrlRx);
  a_r3_bus1_cause: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !bus1DrvN) |-> ($past(!ctrlTx) || $past(!expTx) || $past(!ctrlRx)));
  a_r3_bus2_cause: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !bus2DrvN) |-> ($past(!ctrlTx) || $past(!expTx) || $past(!ctrlRx)));
endmodule

bind canBusRelay canBusRelayChecker i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ctrlTx  (ctrlTx),
  .expTx   (expTx),
  .bus1EnN (bus1EnN),
  .bus2EnN (bus2EnN),
  .bus1DrvN(bus1DrvN),
  .bus2DrvN(bus2DrvN),
  .ctrlRx  (ctrlRx),
  .expRx   (expRx)
);

// File: tb/test_canBusRelay.sv
module test_canBusRelay;
  localparam int SYNC   = 2;
  localparam int HOLD   = 4;
  localparam int LOCK   = 2;
  localparam int SETTLE = SYNC + HOLD + LOCK + 6;

  logic clk = 1'b0;
  logic rstN, ctrlTx, expTx, bus1EnN, bus2EnN, bus1Rx, bus2Rx;
  logic bus1DrvN, bus2DrvN, ctrlRx, expRx;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  canBusRelay #(.SYNC_STAGES(SYNC), .HOLD_CYC(HOLD), .LOCK_CYC(LOCK)) i_canBusRelay (
    .clk(clk), .rstN(rstN), .ctrlTx(ctrlTx), .expTx(expTx),
    .bus1EnN(bus1EnN), .bus2EnN(bus2EnN), .bus1Rx(bus1Rx), .bus2Rx(bus2Rx),
    .bus1DrvN(bus1DrvN), .bus2DrvN(bus2DrvN), .ctrlRx(ctrlRx), .expRx(expRx)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic goIdle();
    ctrlTx = 1'b1; expTx = 1'b1; bus1EnN = 1'b0; bus2EnN = 1'b0;
    bus1Rx = 1'b1; bus2Rx = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    goIdle();
    cyc(3);
    check("R1 reset bus1DrvN", bus1DrvN, 1'b1);
    check("R1 reset bus2DrvN", bus2DrvN, 1'b1);
    check("R1 reset ctrlRx", ctrlRx, 1'b1);
    check("R1 reset expRx", expRx, 1'b1);
    rstN = 1'b1;
    cyc(SETTLE);

    // R3/R6/R7: bus 1 relayed, echo on bus 2 clears inside the hold
    bus1Rx = 1'b0;                        // N(k-1)
    cyc(2);                               // N(k+1)
    check("R3 ctrlRx after sync", ctrlRx, 1'b0);
    check("R3 expRx after sync", expRx, 1'b0);
    check("R3 bus2 not yet driven", bus2DrvN, 1'b1);
    cyc(1);                               // N(k+2)
    check("R3 bus2 driven", bus2DrvN, 1'b0);
    check("R3 bus1 not driven", bus1DrvN, 1'b1);
    bus2Rx = 1'b0;                        // echo
    for (int t = 0; t < 4; t++) begin
      cyc(1);
      check("R6 echo not relayed to bus1", bus1DrvN, 1'b1);
    end
    bus1Rx = 1'b1;                        // N(j-1)
    cyc(2);
    bus2Rx = 1'b0;
    bus2Rx = 1'b1;                        // echo clears at N(j+1)
    for (int t = 0; t < 12; t++) begin
      cyc(1);
      check("R7 echo within hold not relayed", bus1DrvN, 1'b1);
    end
    check("R6 ctrlRx back recessive", ctrlRx, 1'b1);
    check("R6 expRx back recessive", expRx, 1'b1);
    cyc(SETTLE);

    // R7: echo outlasts hold and is then relayed on edge HOLD+1 after drop
    bus1Rx = 1'b0;
    cyc(3);
    bus2Rx = 1'b0;
    cyc(4);
    bus1Rx = 1'b1;                        // N(j-1)
    cyc(HOLD + 2);                        // N(j+1+HOLD)
    check("R7 still held bus1DrvN", bus1DrvN, 1'b1);
    check("R6 masked echo ctrlRx", ctrlRx, 1'b1);
    cyc(1);                               // N(j+2+HOLD)
    check("R7 hold over bus1DrvN", bus1DrvN, 1'b1);
    check("R7 hold over ctrlRx", ctrlRx, 1'b0);
    cyc(1);                               // N(j+3+HOLD)
    check("R7 late echo relayed", bus1DrvN, 1'b0);
    bus2Rx = 1'b1;
    cyc(SETTLE);

    // R9: lockout after bus 1 release
    bus1Rx = 1'b0;
    cyc(4);
    bus1Rx = 1'b1;                        // N(j-1)
    cyc(3);                               // N(j+2)
    ctrlTx = 1'b0;
    cyc(1);                               // N(j+3)
    check("R2 bus2 driven from ctrlTx", bus2DrvN, 1'b0);
    check("R9 bus1 locked", bus1DrvN, 1'b1);
    cyc(LOCK - 1);                        // N(j+2+LOCK)
    check("R9 bus1 locked last", bus1DrvN, 1'b1);
    cyc(1);                               // N(j+3+LOCK)
    check("R9 bus1 driven after lock", bus1DrvN, 1'b0);
    ctrlTx = 1'b1;
    cyc(SETTLE);

    // R8: both buses dominant together, released in turn
    begin
      int nCtrl = 0, nExp = 0, nD1 = 0, nD2 = 0;
      logic pC, pE, p1, p2;
      pC = ctrlRx; pE = expRx; p1 = bus1DrvN; p2 = bus2DrvN;
      bus1Rx = 1'b0; bus2Rx = 1'b0;
      for (int t = 0; t < 30; t++) begin
        cyc(1);
        if (ctrlRx != pC)   nCtrl++;
        if (expRx != pE)    nExp++;
        if (bus1DrvN != p1) nD1++;
        if (bus2DrvN != p2) nD2++;
        pC = ctrlRx; pE = expRx; p1 = bus1DrvN; p2 = bus2DrvN;
        if (t == 5)  bus1Rx = 1'b1;
        if (t == 11) bus2Rx = 1'b1;
      end
      check("R8 ctrlRx two edges", (nCtrl == 2), 1'b1);
      check("R8 expRx two edges", (nExp == 2), 1'b1);
      check("R8 bus1DrvN two edges", (nD1 == 2), 1'b1);
      check("R8 bus2DrvN two edges", (nD2 == 2), 1'b1);
      check("R8 ends recessive", ctrlRx & bus1DrvN & bus2DrvN, 1'b1);
    end
    cyc(SETTLE);

    // R5/R4: disabling a driven bus
    ctrlTx = 1'b0;
    cyc(1);
    check("R2 bus1 driven", bus1DrvN, 1'b0);
    check("R2 bus2 driven", bus2DrvN, 1'b0);
    bus1EnN = 1'b1;
    #1;
    check("R5 bus1 released same cycle", bus1DrvN, 1'b1);
    check("R5 bus2 unaffected", bus2DrvN, 1'b0);
    check("R4 ctrlRx low with bus1 off", ctrlRx, 1'b0);
    cyc(2);
    check("R5 bus1 stays released", bus1DrvN, 1'b1);
    goIdle();
    cyc(SETTLE);

    // Exhaustive static sweep: R2 R3 R4 R5 R10
    for (int c = 0; c < 64; c++) begin
      logic eC, eD1, eD2, eCR, eER, d1, d2, loc;
      ctrlTx = c[0]; expTx = c[1]; bus1EnN = c[2]; bus2EnN = c[3];
      bus1Rx = c[4]; bus2Rx = c[5];
      cyc(SETTLE);
      loc = !c[0] || !c[1];
      d1  = !c[4] && !c[2];
      d2  = !c[5] && !c[3];
      if (loc) begin
        eD1 = c[2]; eD2 = c[3]; eCR = 1'b0; eER = c[0];
      end else begin
        eD1 = !(!c[2] && d2); eD2 = !(!c[3] && d1);
        eCR = !(d1 || d2);    eER = eCR;
      end
      eC = eCR;
      check($sformatf("R2 R3 R5 sweep %0d bus1DrvN", c), bus1DrvN, eD1);
      check($sformatf("R2 R3 R5 sweep %0d bus2DrvN", c), bus2DrvN, eD2);
      check($sformatf("R4 R3 sweep %0d ctrlRx", c), ctrlRx, eC);
      check($sformatf("R10 sweep %0d expRx", c), expRx, eER);
      goIdle();
      cyc(SETTLE);
      check($sformatf("R1 sweep %0d idle", c), bus1DrvN & bus2DrvN & ctrlRx & expRx, 1'b1);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule